// File: doc/BRIEF.md
# I2C SCL Hang Timeout Detector

This block watches a multi-master I2C bus for a hang: the bus is marked busy while the clock line sits high and never toggles again. A free-running counter advances once per clock-enable tick, but only while the bus is busy and SCL is high. When the counter passes its rollover point, a sticky timeout flag is set and an interrupt is raised. Software can pick a long rollover or a short one. After the event, the counter starts again from zero. Once software sees the flag, it is expected to shut the interface down.

The same small control/status register also holds a STOP-detected flag. This flag is set by a pulse from the bus front end, and software can only clear it. A single interrupt line combines both flags. The tick comes from the I2C system clock divider outside this block. For example, with a 4 MHz tick the default widths give about 16.4 ms in long mode and 4.1 ms in short mode.

Register layout (4 bits, read on `ctrlStatus`, written through `wrEn`/`wrData`):

| Bit | Field |
|-----|-------|
| 0 | timeout enable |
| 1 | timeout flag |
| 2 | short-period select |
| 3 | STOP flag |

Top module: `scl_hang_watch`

## Requirements
- R1: After reset, all four register bits and `irq` are 0.
- R2: The counter advances only on a cycle where `tick` is 1, the enable (bit 0) is 1, `busBusy` is 1 and `sclHigh` is 1. Cycles without a tick do not advance it.
- R3: The timeout flag (bit 1) becomes 1 at the clock edge of the 2^SHORT_BITS-th counted tick when bit 2 is 1. It becomes 1 at the edge of the 2^LONG_BITS-th counted tick when bit 2 is 0. Counting starts from a cleared counter.
- R4: The counter clears to zero on any cycle where `sclHigh` or `busBusy` is 0. Each new high stretch is therefore timed from zero.
- R5: The counter returns to zero on the tick that raises a timeout. A further full period of ticks is then needed for the next timeout.
- R6: The timeout flag is sticky. A write with `wrData[1]`=0 clears it, and a write with `wrData[1]`=1 leaves it unchanged. If a timeout and a clearing write fall in the same cycle, the flag ends up 1.
- R7: The STOP flag (bit 3) becomes 1 on the edge after a cycle with `stopSeen`=1. A write with `wrData[3]`=0 clears it, and a write with `wrData[3]`=1 leaves it unchanged. A simultaneous set and clear leaves it 1.
- R8: `irq` is 1 exactly when the STOP flag is 1, or when both the timeout flag and the enable are 1. With the enable at 0, no timeout occurs and a held timeout flag does not drive `irq`.
- R9: A write to bit 2 while counting keeps the current count. The new limit applies from the next tick. If the count is already at or above the short limit when short mode is selected, the next tick raises the timeout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter enable, one pulse per I2C system clock period |
| busBusy | input | 1 | Bus-busy flag from the bus monitor |
| sclHigh | input | 1 | Synchronized SCL level |
| stopSeen | input | 1 | One-cycle pulse when a STOP condition is detected |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 4 | Register write data |
| ctrlStatus | output | 4 | Register contents |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with LONG_BITS=6 and SHORT_BITS=4, so the two periods are 64 and 16 ticks. This puts the exact overflow tick in both modes within a few dozen cycles. It also makes it cheap to count one tick short of the period and one tick on it. The short periods leave room to switch modes mid-count, to restart after a timeout, and to clear the count mid-stretch and then count a full period again.

// File: rtl/scl_hang_pkg.sv
package scl_hang_pkg;
  localparam int REG_W    = 4;
  localparam int BIT_EN   = 0;
  localparam int BIT_TOF  = 1;
  localparam int BIT_SEL  = 2;
  localparam int BIT_STOP = 3;

  // strobes from control to the counting datapath
  typedef struct packed {
    logic run;        // advance this cycle
    logic clear;      // hold at zero
    logic shortMode;  // compare against the short limit
  } cnt_ctl_t;
endpackage

// File: rtl/scl_hang_count.sv
module scl_hang_count #(
  parameter int LONG_BITS  = 16,
  parameter int SHORT_BITS = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  scl_hang_pkg::cnt_ctl_t   cntCtl,
  output logic                     overflow
);
  localparam logic [LONG_BITS-1:0] LONG_MAX  = '1;
  localparam logic [LONG_BITS-1:0] SHORT_MAX = LONG_MAX >> (LONG_BITS - SHORT_BITS);

  logic [LONG_BITS-1:0] count;
  logic [LONG_BITS-1:0] limit;

  // a count already past the short limit overflows on its next tick
  always_comb begin
    limit    = cntCtl.shortMode ? SHORT_MAX : LONG_MAX;
    overflow = cntCtl.run && (count >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         count <= '0;
    else if (cntCtl.clear || overflow)  count <= '0;
    else if (cntCtl.run)                count <= count + 1'b1;
  end
endmodule

// File: rtl/scl_hang_ctrl.sv
module scl_hang_ctrl
  import scl_hang_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             busBusy,
  input  logic             sclHigh,
  input  logic             stopSeen,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             overflow,
  output cnt_ctl_t         cntCtl,
  output logic [REG_W-1:0] ctrlStatus,
  output logic             irq
);
  logic enable, shortSel, toFlag, stopFlag;
  logic armed;

  always_comb begin
    armed            = enable && busBusy && sclHigh;
    cntCtl.run       = armed && tick;
    cntCtl.clear     = !armed;
    cntCtl.shortMode = shortSel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable   <= 1'b0;
      shortSel <= 1'b0;
      toFlag   <= 1'b0;
      stopFlag <= 1'b0;
    end else begin
      if (wrEn) begin
        enable   <= wrData[BIT_EN];
        shortSel <= wrData[BIT_SEL];
      end
      // hardware set takes priority over a software clear
      if (overflow)                        toFlag <= 1'b1;
      else if (wrEn && !wrData[BIT_TOF])   toFlag <= 1'b0;
      if (stopSeen)                        stopFlag <= 1'b1;
      else if (wrEn && !wrData[BIT_STOP])  stopFlag <= 1'b0;
    end
  end

  always_comb begin
    ctrlStatus           = '0;
    ctrlStatus[BIT_EN]   = enable;
    ctrlStatus[BIT_TOF]  = toFlag;
    ctrlStatus[BIT_SEL]  = shortSel;
    ctrlStatus[BIT_STOP] = stopFlag;
    irq                  = stopFlag || (toFlag && enable);
  end
endmodule

// File: rtl/scl_hang_watch.sv
module scl_hang_watch #(
  parameter int LONG_BITS  = 16,
  parameter int SHORT_BITS = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       busBusy,
  input  logic       sclHigh,
  input  logic       stopSeen,
  input  logic       wrEn,
  input  logic [3:0] wrData,
  output logic [3:0] ctrlStatus,
  output logic       irq
);
  scl_hang_pkg::cnt_ctl_t cntCtl;
  logic overflow;

  scl_hang_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busBusy(busBusy),
    .sclHigh(sclHigh), .stopSeen(stopSeen), .wrEn(wrEn), .wrData(wrData),
    .overflow(overflow), .cntCtl(cntCtl), .ctrlStatus(ctrlStatus), .irq(irq)
  );

  scl_hang_count #(.LONG_BITS(LONG_BITS), .SHORT_BITS(SHORT_BITS)) u_count (
    .clk(clk), .rst_n(rst_n), .cntCtl(cntCtl), .overflow(overflow)
  );
endmodule

// File: rtl/scl_hang_watch_chk.sv
module scl_hang_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       busBusy,
  input logic       sclHigh,
  input logic       stopSeen,
  input logic       wrEn,
  input logic       wrTofBit,
  input logic       wrStopBit,
  input logic [3:0] ctrlStatus,
  input logic       irq
);
  // R3 / R2: a timeout only appears after a counted tick
  a_r3_rise_on_run_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrlStatus[1]) |-> $past(tick && busBusy && sclHigh && ctrlStatus[0]));

  // R6: timeout flag holds unless a clearing write occurs
  a_r6_tof_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlStatus[1] && !(wrEn && !wrTofBit)) |=> ctrlStatus[1]);

  // R7: STOP pulse sets the flag on the next edge
  a_r7_stop_sets: assert property (@(posedge clk) disable iff (!rst_n)
    stopSeen |=> ctrlStatus[3]);

  // R7: STOP flag holds unless a clearing write occurs
  a_r7_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrlStatus[3] && !(wrEn && !wrStopBit)) |=> ctrlStatus[3]);

  // R8: with enable low and no STOP flag the interrupt stays quiet
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlStatus[0] && !ctrlStatus[3]) |-> !irq);

  // R8: a STOP flag always requests an interrupt
  a_r8_stop_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlStatus[3] |-> irq);
endmodule

bind scl_hang_watch scl_hang_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busBusy(busBusy),
  .sclHigh(sclHigh), .stopSeen(stopSeen), .wrEn(wrEn),
  .wrTofBit(wrData[1]), .wrStopBit(wrData[3]),
  .ctrlStatus(ctrlStatus), .irq(irq)
);

// File: tb/scl_hang_watch_bench.sv
module scl_hang_watch_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, busBusy = 1'b0, sclHigh = 1'b0, stopSeen = 1'b0, wrEn = 1'b0;
  logic [3:0] wrData = 4'h0;
  logic [3:0] ctrlStatus;
  logic irq;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  scl_hang_watch #(.LONG_BITS(6), .SHORT_BITS(4)) u_scl_hang_watch (
    .clk(clk), .rst_n(rst_n), .tick(tick), .busBusy(busBusy), .sclHigh(sclHigh),
    .stopSeen(stopSeen), .wrEn(wrEn), .wrData(wrData),
    .ctrlStatus(ctrlStatus), .irq(irq)
  );

  // {shortSel, enable, ticks[7:0], expected timeout}
  localparam int NV = 7;
  localparam logic [10:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'd15, 1'b0},
    {1'b1, 1'b1, 8'd16, 1'b1},
    {1'b0, 1'b1, 8'd63, 1'b0},
    {1'b0, 1'b1, 8'd64, 1'b1},
    {1'b0, 1'b1, 8'd20, 1'b0},
    {1'b0, 1'b0, 8'd64, 1'b0},
    {1'b1, 1'b0, 8'd40, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d; tick = 1'b0;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic runTicks(input int n);
    @(negedge clk); busBusy = 1'b1; sclHigh = 1'b1; tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); busBusy = 1'b0; sclHigh = 1'b0; tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reg", ctrlStatus, 0);
    check("R1 irq", irq, 0);

    // table walk: period boundaries, enable gating
    for (int i = 0; i < NV; i++) begin
      writeReg({1'b0, VEC[i][10], 1'b0, VEC[i][9]});
      idle();
      runTicks(VEC[i][8:1]);
      check("R3 tof", ctrlStatus[1], VEC[i][0]);
      check("R8 irq", irq, VEC[i][0]);
      idle();
      writeReg(4'b0000);
    end

    // R2: cycles without a tick do not count
    writeReg(4'b0101); idle();
    @(negedge clk); busBusy = 1'b1; sclHigh = 1'b1; tick = 1'b0;
    repeat (50) @(negedge clk);
    runTicks(15);
    check("R2 no tick no count", ctrlStatus[1], 0);
    runTicks(1);
    check("R2 sixteenth tick", ctrlStatus[1], 1);

    // R5: restart from zero after timeout, SCL still held high
    writeReg(4'b0101);
    check("R6 clear", ctrlStatus[1], 0);
    runTicks(15);
    check("R5 one short", ctrlStatus[1], 0);
    runTicks(1);
    check("R5 full period again", ctrlStatus[1], 1);

    // R4: SCL low clears the count
    idle(); writeReg(4'b0101);
    runTicks(10);
    @(negedge clk); sclHigh = 1'b0; @(negedge clk);
    runTicks(10);
    check("R4 scl low clears", ctrlStatus[1], 0);
    runTicks(6);
    check("R4 full after clear", ctrlStatus[1], 1);

    // R4: busy drop clears the count
    idle(); writeReg(4'b0101);
    runTicks(10);
    @(negedge clk); busBusy = 1'b0; @(negedge clk);
    runTicks(10);
    check("R4 busy drop clears", ctrlStatus[1], 0);

    // R9: switch long->short mid-count at 20 ticks
    idle(); writeReg(4'b0001);
    runTicks(20);
    check("R9 long not yet", ctrlStatus[1], 0);
    writeReg(4'b0111);
    check("R9 sel written", ctrlStatus[2], 1);
    runTicks(1);
    check("R9 next tick overflows", ctrlStatus[1], 1);

    // R6: set wins over clear in the same cycle
    idle(); writeReg(4'b0101);
    runTicks(15);
    @(negedge clk); tick = 1'b1; wrEn = 1'b1; wrData = 4'b0101;
    @(negedge clk); wrEn = 1'b0; tick = 1'b0;
    check("R6 set beats clear", ctrlStatus[1], 1);
    idle();
    writeReg(4'b0111);
    check("R6 write one keeps", ctrlStatus[1], 1);

    // R8: disabling hides a held timeout flag from irq
    writeReg(4'b0110);
    check("R8 flag held", ctrlStatus[1], 1);
    check("R8 irq masked", irq, 0);
    writeReg(4'b0111);
    check("R8 irq unmasked", irq, 1);
    writeReg(4'b0101);
    check("R6 write zero clears", ctrlStatus[1], 0);
    check("R8 irq low", irq, 0);

    // R7: STOP flag
    @(negedge clk); stopSeen = 1'b1;
    @(negedge clk); stopSeen = 1'b0;
    check("R7 stop set", ctrlStatus[3], 1);
    check("R8 stop irq", irq, 1);
    writeReg(4'b1101);
    check("R7 write one keeps", ctrlStatus[3], 1);
    @(negedge clk); stopSeen = 1'b1; wrEn = 1'b1; wrData = 4'b0101;
    @(negedge clk); stopSeen = 1'b0; wrEn = 1'b0;
    check("R7 set beats clear", ctrlStatus[3], 1);
    writeReg(4'b0101);
    check("R7 write zero clears", ctrlStatus[3], 0);
    check("R7 irq low", irq, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule